// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Sequencer

This block supplies the feedback divider of a fractional-N frequency synthesizer with a fresh integer division ratio on every comparison-rate clock. A cascade of three modulo accumulators forms a third-order sigma-delta modulator. Each accumulator wraps at a programmable modulus rather than at a power of two. The overflow bits of the three stages are merged by a noise-cancellation network into a signed correction from −3 to +4. That correction is added to the programmed integer part. Over time the divider then averages exactly integer + numerator/modulus.

Software writes a channel in one strobe: integer part, numerator, modulus and a dither enable. A legal write takes effect atomically and restarts the modulator from a cleared state. A write that breaks the setting rules is refused and raises an error flag. When dither is on, a 21-bit pseudo-random bit is added into the first accumulator. This breaks up the periodic quantisation pattern. The modulator advances only on cycles where the reference-rate enable is high.

Top module: `fracn_sdm_ctrl`

## Requirements
- R1: After reset the output ratio equals the default integer part (32), the error flag is 0, and the numerator is 0.
- R2: With dither off, the sum of the output ratios over one full repeat period L, taken after the first period, equals INT×L + FRAC×L/MOD.
- R3: With dither off and FRAC coprime to MOD, the output sequence repeats with the smallest period L. L is 6×MOD when MOD is a multiple of 6, 2×MOD when MOD is even but not a multiple of 3, 3×MOD when MOD is a multiple of 3 but odd, and MOD otherwise.
- R4: Every output ratio lies within INT−3 to INT+4.
- R5: While the reference enable is low and no load is given, the output and all modulator state hold. The sequence resumes where it stopped.
- R6: A legal load updates INT, FRAC, MOD and dither together, clears the error flag, and clears all accumulator, delay and dither state. The output equals the new INT one clock after the load, so loading the same channel twice gives the same sequence.
- R7: A load is refused, with the error flag set to 1 from the next clock and all settings and the output unchanged, if any of these holds: FRAC ≥ MOD; MOD < 13; dither is on and MOD < 50; INT < 3 or INT > 2^16−5.
- R8: With dither on, the sequence differs from the undithered one for the same channel and still keeps to the R4 window.
- R9: With FRAC = 0 and dither off, the output is constantly INT.
- R10: For MOD = 130, INT = 37, FRAC = 2 and dither off, the output ratios sum to 9624 over 260 cycles, which is an average of 37 + 2/130.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Advance the modulator by one step (one reference period) |
| ld | input | 1 | Load strobe for a new channel setting |
| ld_int | input | 16 | Integer part of the ratio |
| ld_frac | input | 12 | Fractional numerator |
| ld_mod | input | 12 | Modulus (fraction denominator) |
| ld_dith | input | 1 | Dither enable |
| div_out | output | 16 | Registered division ratio for the current reference period |
| cfg_err | output | 1 | High after a refused load, until the next legal load |

## Verification
The ratio of step n is registered on the edge that consumes the enable for step n. The bench raises the enable on a falling edge and reads the output on each later falling edge, half a period after the register updates. A load takes effect on the edge after the strobe, so the new INT and the error flag are read on the falling edge that ends the strobe. That is also the point where a refused load is shown to leave the output untouched. Periods, sums and windows are computed from the captured ratios alone. Comparisons between runs line up step indices counted from each load, not wall-clock cycles.

// File: rtl/fracn_sdm_pkg.sv
package fracn_sdm_pkg;
  typedef logic signed [3:0] corr_t;
  localparam int unsigned MOD_FLOOR_PLAIN  = 13;
  localparam int unsigned MOD_FLOOR_DITHER = 50;
  localparam int unsigned INT_FLOOR        = 3;
endpackage

// File: rtl/fracn_modacc.sv
module fracn_modacc #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] mod_i,
  input  logic [W:0]   inc_i,
  output logic [W-1:0] nxt_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W+1:0] sum;

  always_comb begin
    sum     = {2'b00, acc_q} + {1'b0, inc_i};
    carry_o = (sum >= {2'b00, mod_i});
    nxt_o   = carry_o ? W'(sum - {2'b00, mod_i}) : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (en)    acc_q <= nxt_o;
  end

  a_r4_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
    acc_q < mod_i);

  a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> acc_q == $past(acc_q));
endmodule

// File: rtl/fracn_lfsr.sv
module fracn_lfsr #(
  parameter int W     = 21,
  parameter int TAP_A = 20,
  parameter int TAP_B = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic bit_o
);
  localparam logic [W-1:0] SEED = W'(1);
  logic [W-1:0] st_q;
  logic         fb;

  assign fb    = st_q[TAP_A] ^ st_q[TAP_B];
  assign bit_o = st_q[W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) st_q <= SEED;
    else if (en)    st_q <= {st_q[W-2:0], fb};
  end

  a_r8_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);
endmodule

// File: rtl/fracn_cancel.sv
module fracn_cancel
  import fracn_sdm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  clr,
  input  logic  c1_i,
  input  logic  c2_i,
  input  logic  c3_i,
  output corr_t corr_o
);
  logic c2_d, c3_d, c3_dd;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (en) begin
      c2_d  <= c2_i;
      c3_d  <= c3_i;
      c3_dd <= c3_d;
    end
  end

  always_comb begin
    corr_o = corr_t'({3'b000, c1_i})
           + corr_t'({3'b000, c2_i}) - corr_t'({3'b000, c2_d})
           + corr_t'({3'b000, c3_i}) - corr_t'({2'b00, c3_d, 1'b0})
           + corr_t'({3'b000, c3_dd});
  end

  a_r6_delays_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!c2_d && !c3_d && !c3_dd));

  a_r4_corr_window: assert property (@(posedge clk) disable iff (rst)
    (corr_o >= -4'sd3) && (corr_o <= 4'sd4));
endmodule

// File: rtl/fracn_sdm_ctrl.sv
module fracn_sdm_ctrl
  import fracn_sdm_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int MOD_W   = 12,
  parameter int DEF_INT = 32,
  parameter int LFSR_W  = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  logic             ld,
  input  logic [INT_W-1:0] ld_int,
  input  logic [MOD_W-1:0] ld_frac,
  input  logic [MOD_W-1:0] ld_mod,
  input  logic             ld_dith,
  output logic [INT_W-1:0] div_out,
  output logic             cfg_err
);
  localparam int ORDER = 3;
  localparam logic [INT_W-1:0] INT_HI = {INT_W{1'b1}} - INT_W'(4);
  localparam logic [INT_W-1:0] INT_LO = INT_W'(INT_FLOOR);

  logic [INT_W-1:0] int_q;
  logic [MOD_W-1:0] frac_q, mod_q;
  logic             dith_q;
  logic             legal, clr, adv, dbit, lfsr_bit;
  logic [MOD_W-1:0] mod_floor;
  logic [MOD_W:0]   inc_w [ORDER];
  logic [MOD_W-1:0] nxt_w [ORDER];
  logic             car_w [ORDER];
  corr_t            corr;
  logic signed [INT_W:0] ratio_s;

  assign mod_floor = ld_dith ? MOD_W'(MOD_FLOOR_DITHER) : MOD_W'(MOD_FLOOR_PLAIN);
  assign legal = (ld_mod >= mod_floor) && (ld_frac < ld_mod)
              && (ld_int >= INT_LO) && (ld_int <= INT_HI);
  assign clr   = ld && legal;
  assign adv   = ref_en && !ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= INT_W'(DEF_INT);
      frac_q <= '0;
      mod_q  <= MOD_W'(MOD_FLOOR_PLAIN);
      dith_q <= 1'b0;
      cfg_err <= 1'b0;
    end else if (ld) begin
      cfg_err <= !legal;
      if (legal) begin
        int_q  <= ld_int;
        frac_q <= ld_frac;
        mod_q  <= ld_mod;
        dith_q <= ld_dith;
      end
    end
  end

  fracn_lfsr #(.W(LFSR_W)) i_lfsr (
    .clk(clk), .rst(rst), .en(adv), .clr(clr), .bit_o(lfsr_bit)
  );
  assign dbit = dith_q && lfsr_bit;

  assign inc_w[0] = {1'b0, frac_q} + {{MOD_W{1'b0}}, dbit};

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k > 0) begin : g_chain
      assign inc_w[k] = {1'b0, nxt_w[k-1]};
    end
    fracn_modacc #(.W(MOD_W)) i_acc (
      .clk(clk), .rst(rst), .en(adv), .clr(clr),
      .mod_i(mod_q), .inc_i(inc_w[k]),
      .nxt_o(nxt_w[k]), .carry_o(car_w[k])
    );
  end

  fracn_cancel i_cancel (
    .clk(clk), .rst(rst), .en(adv), .clr(clr),
    .c1_i(car_w[0]), .c2_i(car_w[1]), .c3_i(car_w[2]),
    .corr_o(corr)
  );

  assign ratio_s = $signed({1'b0, int_q}) + {{(INT_W-3){corr[3]}}, corr};

  always_ff @(posedge clk) begin
    if (rst)      div_out <= INT_W'(DEF_INT);
    else if (clr) div_out <= ld_int;
    else if (adv) div_out <= ratio_s[INT_W-1:0];
  end

  a_r4_out_window: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, div_out} + (INT_W+1)'(3)) >= {1'b0, int_q})
    && ({1'b0, div_out} <= ({1'b0, int_q} + (INT_W+1)'(4))));

  a_r7_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (ld && !legal) |=> (cfg_err && int_q == $past(int_q) && frac_q == $past(frac_q)
                        && mod_q == $past(mod_q) && div_out == $past(div_out)));

  a_r6_load_applies: assert property (@(posedge clk) disable iff (rst)
    (ld && legal) |=> (!cfg_err && div_out == $past(ld_int)));

  a_r5_pause_holds: assert property (@(posedge clk) disable iff (rst)
    (!ref_en && !ld) |=> $stable(div_out));

  a_r9_zero_frac_flat: assert property (@(posedge clk) disable iff (rst)
    (frac_q == '0 && !dith_q) |-> (div_out == int_q));

  a_r2_last_stage_bounded: assert property (@(posedge clk) disable iff (rst)
    nxt_w[ORDER-1] < mod_q);
endmodule

// File: tb/test_fracn_sdm_ctrl.sv
module test_fracn_sdm_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_en = 1'b0;
  logic        ld = 1'b0;
  logic [15:0] ld_int = '0;
  logic [11:0] ld_frac = '0;
  logic [11:0] ld_mod = '0;
  logic        ld_dith = 1'b0;
  logic [15:0] div_out;
  logic        cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int cap  [1024];
  int refs [1024];

  always #10ns clk = ~clk;

  fracn_sdm_ctrl i_fracn_sdm_ctrl (
    .clk(clk), .rst(rst), .ref_en(ref_en), .ld(ld),
    .ld_int(ld_int), .ld_frac(ld_frac), .ld_mod(ld_mod), .ld_dith(ld_dith),
    .div_out(div_out), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(input int iv, input int fv, input int mv, input bit dv);
    @(negedge clk);
    ref_en = 1'b0;
    ld = 1'b1; ld_int = 16'(iv); ld_frac = 12'(fv); ld_mod = 12'(mv); ld_dith = dv;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic run(input int n, input int off);
    ref_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap[off+i] = int'(div_out);
    end
    ref_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(div_out == 16'd32, "R1 reset ratio", int'(div_out), 32);
    chk(cfg_err == 1'b0, "R1 reset error flag", int'(cfg_err), 0);
    run(20, 0);
    for (int i = 0; i < 20; i++)
      if (cap[i] != 32) begin chk(0, "R1 reset numerator zero", cap[i], 32); break; end
  endtask

  task automatic t_zero_frac();
    int bad = 0;
    load(100, 0, 13, 0);
    chk(div_out == 16'd100, "R6 new INT after load", int'(div_out), 100);
    run(40, 0);
    for (int i = 0; i < 40; i++) if (cap[i] != 100) bad++;
    chk(bad == 0, "R9 flat output with FRAC=0", bad, 0);
  endtask

  task automatic t_period(input int iv, input int fv, input int mv, input int el, input bit do_per);
    int sum = 0, lo = 0, hi = 0, bad = 0, exp_sum;
    load(iv, fv, mv, 0);
    run(3*el, 0);
    for (int i = 0; i < 3*el; i++) begin
      if (cap[i] < iv - 3) lo++;
      if (cap[i] > iv + 4) hi++;
    end
    chk(lo == 0 && hi == 0, "R4 ratio window", lo + hi, 0);
    for (int i = el; i < 2*el; i++) sum += cap[i];
    exp_sum = iv*el + (fv*el)/mv;
    chk(sum == exp_sum, (mv == 130) ? "R10 worked channel sum" : "R2 period sum", sum, exp_sum);
    if (do_per) begin
      for (int i = el; i < 2*el; i++) if (cap[i] != cap[i+el]) bad++;
      chk(bad == 0, "R3 repeats at L", bad, 0);
      for (int d = 2; d <= el; d++) begin
        if (el % d == 0) begin
          int same = 1;
          for (int i = el; i < 2*el; i++) if (cap[i] != cap[i + el/d]) same = 0;
          chk(same == 0, "R3 no shorter period", el/d, el);
        end
      end
    end
  endtask

  task automatic t_pause();
    int bad = 0;
    load(40, 5, 17, 0);
    run(30, 0);
    for (int i = 0; i < 30; i++) refs[i] = cap[i];
    load(40, 5, 17, 0);
    run(10, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (int'(div_out) != cap[9]) bad++;
    end
    chk(bad == 0, "R5 output held while enable low", bad, 0);
    run(20, 10);
    bad = 0;
    for (int i = 0; i < 30; i++) if (cap[i] != refs[i]) bad++;
    chk(bad == 0, "R5 sequence resumes in place", bad, 0);
    chk(refs[0] == cap[0], "R6 reload repeats sequence", cap[0], refs[0]);
  endtask

  task automatic t_reject();
    int bad = 0, held;
    load(40, 5, 17, 0);
    run(30, 0);
    for (int i = 0; i < 30; i++) refs[i] = cap[i];
    load(40, 5, 17, 0);
    run(10, 0);
    held = cap[9];
    load(40, 17, 17, 0);
    chk(cfg_err == 1'b1, "R7 FRAC>=MOD refused", int'(cfg_err), 1);
    chk(int'(div_out) == held, "R7 output kept (FRAC>=MOD)", int'(div_out), held);
    load(40, 0, 12, 0);
    chk(cfg_err == 1'b1, "R7 MOD<13 refused", int'(cfg_err), 1);
    load(40, 1, 40, 1);
    chk(cfg_err == 1'b1, "R7 dither MOD<50 refused", int'(cfg_err), 1);
    load(2, 1, 60, 0);
    chk(cfg_err == 1'b1, "R7 INT<3 refused", int'(cfg_err), 1);
    load(65532, 1, 60, 0);
    chk(cfg_err == 1'b1, "R7 INT too large refused", int'(cfg_err), 1);
    chk(int'(div_out) == held, "R7 output kept after refusals", int'(div_out), held);
    run(20, 10);
    for (int i = 0; i < 30; i++) if (cap[i] != refs[i]) bad++;
    chk(bad == 0, "R7 settings unchanged by refused loads", bad, 0);
    load(40, 5, 17, 0);
    chk(cfg_err == 1'b0, "R6 legal load clears error", int'(cfg_err), 0);
  endtask

  task automatic t_dither();
    int diff = 0, out_win = 0;
    load(20, 1, 60, 0);
    run(200, 0);
    for (int i = 0; i < 200; i++) refs[i] = cap[i];
    load(20, 1, 60, 1);
    chk(cfg_err == 1'b0, "R8 dither MOD=60 accepted", int'(cfg_err), 0);
    run(200, 0);
    for (int i = 0; i < 200; i++) begin
      if (cap[i] != refs[i]) diff++;
      if (cap[i] < 17 || cap[i] > 24) out_win++;
    end
    chk(diff > 0, "R8 dither changes sequence", diff, 1);
    chk(out_win == 0, "R8 dithered ratio in window", out_win, 0);
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_frac();
    t_period(50, 1, 13, 13, 1);
    t_period(50, 3, 14, 28, 1);
    t_period(50, 2, 15, 45, 1);
    t_period(50, 7, 30, 180, 1);
    t_period(37, 2, 130, 260, 0);
    t_pause();
    t_reject();
    t_dither();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule